// File: doc/BRIEF.md
# DMA Channel Transfer Mode Sequencer

This block is the control core of a single DMA channel. A 3-bit mode code selects three things at once. It picks what starts a transfer: a peripheral request, or the enable bit alone. It picks how many words one trigger moves: the whole block, one word, or one line. It also decides whether the channel enable clears itself when the block finishes. The block keeps the channel enable bit and a down-counter of remaining words. It reloads that counter from a preload value at the end of every block.

Each word is offered on a valid/ready strobe pair, and a word moves in a cycle where both are high. The channel interrupt is raised at the end of a block, or when software drops the enable while a transfer is running. It is held until the service routine acknowledges it. Address generation, the data path and arbitration sit outside this block.

Top module: `dma_mode_seq`

## Requirements
- R1: After reset, `en_o`, `irq_o` and `xfer_valid_o` are low and `cnt_o` is zero.
- R2: Mode 3'b000: a single request moves the whole block, and `en_o` clears when the last word moves.
- R3: Mode 3'b001: each request moves exactly one word, and `en_o` clears when the last word of the block moves.
- R4: Mode 3'b010: each request moves `line_len_i` words, or fewer if the block ends first, and `en_o` clears at block end.
- R5: Mode 3'b011: setting the enable starts the whole block with no request, and `en_o` clears at block end.
- R6: Mode 3'b100: each request moves a whole block, and `en_o` stays set afterwards so the channel waits for the next request.
- R7: Mode 3'b101: each request moves one word, the counter wraps to the preload at block end, and `en_o` is never cleared by the block.
- R8: `cnt_o` loads `preload_i` when the enable goes from 0 to 1. It drops by one for every word moved (`xfer_valid_o && xfer_ready_i`) and reloads `preload_i` on the last word of a block.
- R9: In modes 000 to 011, `irq_o` rises at block end when `ie_i` is high. No end-of-block interrupt occurs in modes 100 and 101, and none occurs while `ie_i` is low.
- R10: Writing the enable to 0 while a word strobe is outstanding withdraws the strobe at once and raises `irq_o` if `ie_i` is high. The same write while idle raises nothing.
- R11: Once high, `irq_o` stays high until `irq_ack_i` is pulsed.
- R12: Reserved codes 3'b110 and 3'b111 produce no transfer and no interrupt.
- R13: Requests that arrive while a word or line is still in progress are merged into one pending request, which starts the next unit.
- R14: While `xfer_ready_i` is low, `xfer_valid_o` holds and the counter does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Transfer mode code |
| en_wr_i | input | 1 | Software write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| ie_i | input | 1 | Interrupt enable |
| preload_i | input | CNT_W | Block length reloaded into the counter |
| line_len_i | input | LINE_W | Words per line in line mode |
| req_i | input | 1 | Peripheral request pulse |
| xfer_valid_o | output | 1 | Word transfer strobe |
| xfer_ready_i | input | 1 | Word accepted by the data path |
| en_o | output | 1 | Current channel enable bit |
| cnt_o | output | CNT_W | Words remaining in the block |
| irq_o | output | 1 | Pending channel interrupt |
| irq_ack_i | input | 1 | Interrupt service acknowledge |

## Verification
The bench builds the block with CNT_W=6 and LINE_W=3, using a 5-word block and 2-word lines. Short blocks let every mode run to its end and through its reload within a few dozen cycles. An odd block length over a 2-word line makes the shortened final line appear. With the ready input held low, requests and an abort arrive while a word is still outstanding, which exercises both the pending-request merge and the abort interrupt.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;
  typedef enum logic [1:0] {GR_BLOCK, GR_WORD, GR_LINE, GR_NONE} grain_e;
  typedef enum logic {ST_IDLE, ST_RUN} state_e;
endpackage

// File: rtl/dma_mode_dec.sv
`timescale 1ns/1ps
module dma_mode_dec
  import dma_seq_pkg::*;
(
  input  logic [2:0] mode_i,
  output logic       valid_o,
  output logic       self_trig_o,
  output logic       auto_clr_o,
  output logic       eob_irq_o,
  output grain_e     grain_o
);
  always_comb begin
    valid_o     = 1'b1;
    self_trig_o = 1'b0;
    auto_clr_o  = ~mode_i[2];
    eob_irq_o   = ~mode_i[2];
    grain_o     = GR_BLOCK;
    case (mode_i)
      3'b000: grain_o = GR_BLOCK;
      3'b001: grain_o = GR_WORD;
      3'b010: grain_o = GR_LINE;
      3'b011: begin grain_o = GR_BLOCK; self_trig_o = 1'b1; end
      3'b100: grain_o = GR_BLOCK;
      3'b101: grain_o = GR_WORD;
      default: begin
        valid_o    = 1'b0;
        auto_clr_o = 1'b0;
        eob_irq_o  = 1'b0;
        grain_o    = GR_NONE;
      end
    endcase
  end
endmodule

// File: rtl/dma_dn_ctr.sv
`timescale 1ns/1ps
module dma_dn_ctr #(
  parameter int unsigned W      = 16,
  parameter bit          RELOAD = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         last;

  assign last = (cnt_q <= ONE);

  generate
    if (RELOAD) begin : g_wrap
      always_comb begin
        cnt_d = cnt_q;
        if (dec_i) cnt_d = last ? val_i : cnt_q - ONE;
        else if (load_i) cnt_d = val_i;
      end
    end else begin : g_sat
      always_comb begin
        cnt_d = cnt_q;
        if (load_i) cnt_d = val_i;
        else if (dec_i) cnt_d = last ? '0 : cnt_q - ONE;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dma_req_latch.sv
`timescale 1ns/1ps
module dma_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic req_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  // several requests during one unit collapse into a single pending one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= armed_i & ~take_i & (pend_q | req_i);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dma_irq_flag.sv
`timescale 1ns/1ps
module dma_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_mode_seq.sv
`timescale 1ns/1ps
module dma_mode_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              en_wr_i,
  input  logic              en_wdata_i,
  input  logic              ie_i,
  input  logic [CNT_W-1:0]  preload_i,
  input  logic [LINE_W-1:0] line_len_i,
  input  logic              req_i,
  output logic              xfer_valid_o,
  input  logic              xfer_ready_i,
  output logic              en_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_o,
  input  logic              irq_ack_i
);
  localparam logic [CNT_W-1:0]  BLK_ONE  = CNT_W'(1);
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

  state_e st_q, st_d;
  logic   en_q, en_d;
  logic   act_clr_q, act_irq_q;
  grain_e act_grain_q;

  logic   m_valid, m_self, m_clr, m_irq;
  grain_e m_grain;

  logic              pend;
  logic [CNT_W-1:0]  blk_cnt;
  logic [LINE_W-1:0] line_cnt;

  logic running, fire, wr_off, abort, en_rise, start, take;
  logic blk_last, line_last, unit_end, eob, irq_set;

  dma_mode_dec u_dec (
    .mode_i      (mode_i),
    .valid_o     (m_valid),
    .self_trig_o (m_self),
    .auto_clr_o  (m_clr),
    .eob_irq_o   (m_irq),
    .grain_o     (m_grain)
  );

  assign running  = (st_q == ST_RUN);
  assign fire     = running & xfer_ready_i;
  assign wr_off   = en_wr_i & ~en_wdata_i;
  assign abort    = wr_off & running;
  assign en_rise  = en_wr_i & en_wdata_i & ~en_q;
  assign start    = ~running & en_q & ~wr_off & m_valid & (m_self | pend | req_i);
  assign take     = start & ~m_self;

  assign blk_last  = (blk_cnt <= BLK_ONE);
  assign line_last = (line_cnt <= LINE_ONE);
  assign eob       = fire & blk_last;
  assign unit_end  = fire & (blk_last
                     | (act_grain_q == GR_WORD)
                     | ((act_grain_q == GR_LINE) & line_last));

  assign irq_set = ie_i & (abort | (eob & act_irq_q));

  dma_req_latch u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (en_q),
    .req_i   (req_i),
    .take_i  (take),
    .pend_o  (pend)
  );

  dma_dn_ctr #(.W(CNT_W), .RELOAD(1'b1)) u_blk_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (en_rise),
    .val_i  (preload_i),
    .dec_i  (fire),
    .cnt_o  (blk_cnt)
  );

  dma_dn_ctr #(.W(LINE_W), .RELOAD(1'b0)) u_line_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .val_i  (line_len_i),
    .dec_i  (fire),
    .cnt_o  (line_cnt)
  );

  dma_irq_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set),
    .ack_i  (irq_ack_i),
    .irq_o  (irq_o)
  );

  always_comb begin
    st_d = st_q;
    if (abort)                  st_d = ST_IDLE;
    else if (running)           st_d = unit_end ? ST_IDLE : ST_RUN;
    else if (start)             st_d = ST_RUN;
  end

  always_comb begin
    en_d = en_q;
    if (en_wr_i)                 en_d = en_wdata_i;
    else if (eob && act_clr_q)   en_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      en_q        <= 1'b0;
      act_clr_q   <= 1'b0;
      act_irq_q   <= 1'b0;
      act_grain_q <= GR_NONE;
    end else begin
      st_q <= st_d;
      en_q <= en_d;
      // mode is captured per unit so the end-of-block actions match the trigger
      if (start) begin
        act_clr_q   <= m_clr;
        act_irq_q   <= m_irq;
        act_grain_q <= m_grain;
      end
    end
  end

  assign xfer_valid_o = running;
  assign en_o         = en_q;
  assign cnt_o        = blk_cnt;
endmodule

// File: rtl/dma_mode_seq_chk.sv
`timescale 1ns/1ps
module dma_mode_seq_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_i,
  input logic             en_wr_i,
  input logic             en_wdata_i,
  input logic             ie_i,
  input logic             xfer_ready_i,
  input logic             xfer_valid_o,
  input logic             en_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             irq_o,
  input logic             irq_ack_i
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_strobe_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> en_o);

  p_irq_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);

  p_cnt_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && xfer_ready_i && cnt_o > ONE) |=> (cnt_o == $past(cnt_o) - ONE));

  p_stall_hold_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && !xfer_ready_i && !(en_wr_i && !en_wdata_i)) |=>
      (xfer_valid_o && $stable(cnt_o)));

  p_reserved_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2:1] == 2'b11 && !xfer_valid_o) |=> !xfer_valid_o);

  p_irq_needs_ie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ie_i));

  p_rearm_keeps_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 3'b100 || mode_i == 3'b101) && en_o && !en_wr_i) |=> en_o);
endmodule

bind dma_mode_seq dma_mode_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .en_wr_i      (en_wr_i),
  .en_wdata_i   (en_wdata_i),
  .ie_i         (ie_i),
  .xfer_ready_i (xfer_ready_i),
  .xfer_valid_o (xfer_valid_o),
  .en_o         (en_o),
  .cnt_o        (cnt_o),
  .irq_o        (irq_o),
  .irq_ack_i    (irq_ack_i)
);

// File: tb/dma_mode_seq_tb_top.sv
`timescale 1ns/1ps
module dma_mode_seq_tb_top;
  localparam int CW = 6;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode = 3'b000;
  logic          en_wr = 1'b0, en_wdata = 1'b0, ie = 1'b0;
  logic [CW-1:0] preload = CW'(5);
  logic [LW-1:0] line_len = LW'(2);
  logic          req = 1'b0, ready = 1'b1, ack = 1'b0;
  logic          valid, en, irq;
  logic [CW-1:0] cnt;

  int checks = 0;
  int failures = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  dma_mode_seq #(.CNT_W(CW), .LINE_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .en_wr_i(en_wr),
    .en_wdata_i(en_wdata), .ie_i(ie), .preload_i(preload),
    .line_len_i(line_len), .req_i(req), .xfer_valid_o(valid),
    .xfer_ready_i(ready), .en_o(en), .cnt_o(cnt), .irq_o(irq),
    .irq_ack_i(ack)
  );

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_en(input logic v);
    en_wr = 1'b1; en_wdata = v; tick(); en_wr = 1'b0;
  endtask

  task automatic pulse_req();
    req = 1'b1; tick(); req = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic expect_words(input int first, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(first - i);
  endtask

  // monitor: every accepted word must match the next expected counter value (R8)
  always @(negedge clk) begin
    if (rst_n && valid && ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R8 unexpected word actual=%0d expected=none", cnt);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(cnt) != e) begin
          failures++;
          $display("FAIL R8 word count actual=%0d expected=%0d", cnt, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    tick();
    check("R1 en", en, 0); check("R1 irq", irq, 0);
    check("R1 valid", valid, 0); check("R1 cnt", cnt, 0);

    // R2 block per request, self-clearing
    mode = 3'b000; ie = 1'b1;
    wr_en(1'b1);
    check("R8 load", cnt, 5);
    expect_words(5, 5);
    pulse_req(); settle(10);
    check("R2 words", exp_q.size(), 0);
    check("R2 en", en, 0);
    check("R8 reload", cnt, 5);
    check("R9 irq", irq, 1);
    settle(3);
    check("R11 held", irq, 1);
    pulse_ack();
    check("R11 ack", irq, 0);

    // R3 word per request
    mode = 3'b001;
    wr_en(1'b1);
    for (int i = 0; i < 5; i++) begin
      expect_words(5 - i, 1);
      pulse_req(); settle(4);
      check("R3 one word", exp_q.size(), 0);
      check("R3 idle", valid, 0);
      if (i < 4) check("R3 en kept", en, 1);
    end
    check("R3 en", en, 0);
    check("R9 irq word", irq, 1);
    pulse_ack();

    // R4 line per request, last line short
    mode = 3'b010;
    wr_en(1'b1);
    expect_words(5, 2); pulse_req(); settle(6);
    check("R4 line1", exp_q.size(), 0); check("R4 idle", valid, 0);
    check("R4 en mid", en, 1);
    expect_words(3, 2); pulse_req(); settle(6);
    check("R4 line2", exp_q.size(), 0);
    expect_words(1, 1); pulse_req(); settle(6);
    check("R4 short", exp_q.size(), 0);
    check("R4 en", en, 0);
    check("R9 irq line", irq, 1);
    pulse_ack();

    // R5 enable-triggered, interrupt disabled
    mode = 3'b011; ie = 1'b0;
    expect_words(5, 5);
    wr_en(1'b1); settle(10);
    check("R5 words", exp_q.size(), 0);
    check("R5 en", en, 0);
    check("R9 no ie", irq, 0);

    // R6 rearming block
    mode = 3'b100; ie = 1'b1;
    wr_en(1'b1);
    expect_words(5, 5); pulse_req(); settle(10);
    check("R6 words", exp_q.size(), 0);
    check("R6 en", en, 1);
    check("R9 none 100", irq, 0);
    expect_words(5, 5); pulse_req(); settle(10);
    check("R6 again", exp_q.size(), 0);
    wr_en(1'b0);
    check("R10 idle off", irq, 0);

    // R7 rearming word
    mode = 3'b101;
    wr_en(1'b1);
    for (int i = 0; i < 6; i++) begin
      expect_words((i < 5) ? 5 - i : 5, 1);
      pulse_req(); settle(4);
    end
    check("R7 words", exp_q.size(), 0);
    check("R7 en", en, 1);
    check("R7 wrap", cnt, 4);
    check("R9 none 101", irq, 0);
    wr_en(1'b0);

    // R13 merged pending requests, R14 stall
    mode = 3'b001; ie = 1'b0; ready = 1'b0;
    wr_en(1'b1);
    expect_words(5, 2);
    pulse_req(); settle(2);
    pulse_req(); settle(1);
    pulse_req(); settle(2);
    check("R14 valid", valid, 1);
    check("R14 cnt", cnt, 5);
    ready = 1'b1; settle(8);
    check("R13 merged", exp_q.size(), 0);
    check("R13 cnt", cnt, 3);
    wr_en(1'b0);

    // R10 abort while stalled
    mode = 3'b100; ie = 1'b1; ready = 1'b0;
    wr_en(1'b1);
    pulse_req(); settle(3);
    check("R10 running", valid, 1);
    wr_en(1'b0);
    check("R10 valid", valid, 0);
    check("R10 en", en, 0);
    check("R10 irq", irq, 1);
    check("R10 cnt", cnt, 5);
    ready = 1'b1; settle(5);
    check("R10 no words", exp_q.size(), 0);
    pulse_ack();

    // R12 reserved codes
    for (int m = 6; m < 8; m++) begin
      mode = 3'(m);
      wr_en(1'b1);
      pulse_req(); settle(6);
      check("R12 valid", valid, 0);
      check("R12 irq", irq, 0);
      check("R12 cnt", cnt, 5);
      wr_en(1'b0);
      check("R12 off irq", irq, 0);
    end

    settle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule